// File: doc/BRIEF.md
# Unaligned Buffer Word Realigner

The realigner sits between a memory-read port and the write port of a tagged transmit FIFO. A packet is announced by a one-cycle start strobe that carries the byte offset of the buffer inside its first 32-bit memory word (0 to 3) and the packet length in bytes. The block then pulls exactly as many memory words as the buffer spans. It shifts and merges their bytes into dense 32-bit payload entries tagged as data, and it finishes every packet with an end-of-packet entry. That entry is the only thing that returns the byte-merging logic to its idle state and discards any bytes still held.

A sequencer shares the same FIFO write port for command entries (tag 0x0). Commands are accepted only while the realigner is idle, and are stalled otherwise, so a command can never be caught in a half-finished merge. If a transfer is cut short by an underrun, the abort input sends the block straight to its end-of-packet step. The tag is written even in that case, so no residual byte state leaks into the next command. A full FIFO stalls the memory side without losing the bytes held between words.

Top module: `unaligned_realigner`

## Requirements
- R1: After reset the block is idle: no FIFO write, no memory read request, and a command is accepted when the FIFO is not full.
- R2: Payload entry j carries tag 0x1 and holds packet bytes 4j..4j+3, with packet byte k taken from memory byte address offset+k (little-endian: memory word w holds byte address 4w+i in bits 8i+7..8i), and packet byte 4j+i in bits 8i+7..8i.
- R3: In the last payload entry, byte lanes at or beyond the packet length are zero.
- R4: Exactly one end-of-packet entry (tag 0x2) follows the last payload entry. Its data is zero except bits 1..0 = length mod 4 and bit 8 = 1 when the packet was aborted.
- R5: A zero-length packet produces only the end-of-packet entry and reads no memory word.
- R6: A packet of length L>0 at offset o consumes exactly ceil((o+L)/4) memory words through the valid/ready handshake.
- R7: A command entry is written with tag 0x0 and its data unchanged, only while no packet is in progress; during a packet the command-ready output stays low.
- R8: No FIFO write happens while the FIFO-full input is high, and a stall of any length loses or duplicates no byte.
- R9: An abort during a packet suppresses all further payload entries and leads to the end-of-packet entry with the abort bit set; the next packet is realigned correctly.
- R10: A start strobe that arrives while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Start a packet (taken only when idle) |
| pkt_offset | input | 2 | Byte offset of the buffer in its first memory word |
| pkt_len | input | LEN_W | Packet length in bytes |
| abort | input | 1 | Underrun abort of the packet in progress |
| rd_valid | input | 1 | Memory word available |
| rd_data | input | 32 | Memory word |
| rd_ready | output | 1 | Memory word taken this cycle when rd_valid is high |
| cmd_valid | input | 1 | Command entry offered |
| cmd_data | input | 32 | Command entry payload |
| cmd_ready | output | 1 | Command taken this cycle when cmd_valid is high |
| fifo_full | input | 1 | FIFO cannot accept an entry |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_tag | output | 4 | Entry tag: 0x0 command, 0x1 payload, 0x2 end of packet |
| fifo_data | output | 32 | Entry data |

## Verification
The bench builds the block with LEN_W = 5, so lengths up to 31 bytes are legal. It sweeps all four offsets against every length from 0 to 23, both with a free-flowing FIFO and memory and with a fixed stall pattern on both. This covers every pairing of residual byte count and trailing-lane count, including the cases where the last entry is drained from held bytes alone. Aborts at several payload positions, commands held against a busy block, and start strobes injected mid-packet are each followed by a clean packet to expose leaked state.

// File: rtl/ur_pkg.sv
package ur_pkg;

  localparam logic [3:0] TAG_CMD  = 4'h0;
  localparam logic [3:0] TAG_DATA = 4'h1;
  localparam logic [3:0] TAG_EOP  = 4'h2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_EOP  = 2'd2
  } ur_state_e;

  // Join the newer word above the held one and drop `off` leading bytes.
  function automatic logic [31:0] ur_merge(input logic [31:0] nxt,
                                           input logic [31:0] held,
                                           input logic [1:0]  off);
    logic [63:0] cat;
    cat = {nxt, held} >> {off, 3'b000};
    return cat[31:0];
  endfunction

  // Lanes kept in the final word; zero residue means all four lanes.
  function automatic logic [31:0] ur_keep(input logic [1:0] nbytes);
    logic [31:0] m;
    case (nbytes)
      2'd1:    m = 32'h0000_00FF;
      2'd2:    m = 32'h0000_FFFF;
      2'd3:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ur_ctrl.sv
module ur_ctrl
  import ur_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [1:0]       pkt_offset,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             abort,
  input  logic             rd_valid,
  input  logic             cmd_valid,
  input  logic             fifo_full,
  output ur_state_e        state,
  output logic             rd_ready,
  output logic             rd_fire,
  output logic             cmd_ready,
  output logic             cmd_fire,
  output logic             data_fire,
  output logic             eop_fire,
  output logic             use_new,
  output logic             last_word,
  output logic             held_valid,
  output logic             aborted_q,
  output logic [1:0]       off_q,
  output logic [1:0]       lsb_q
);

  localparam int SUM_W = LEN_W + 2;

  ur_state_e        st;
  logic [LEN_W-1:0] in_left;
  logic [LEN_W-1:0] out_left;
  logic [SUM_W-1:0] in_sum;
  logic [SUM_W-1:0] out_sum;
  logic [LEN_W-1:0] in_words;
  logic [LEN_W-1:0] out_words;
  logic             start_take;
  logic             in_active;

  // word counts for a new packet
  always_comb begin
    in_sum    = SUM_W'(pkt_len) + SUM_W'(pkt_offset) + SUM_W'(3);
    out_sum   = SUM_W'(pkt_len) + SUM_W'(3);
    in_words  = (pkt_len == '0) ? '0 : in_sum[SUM_W-1:2];
    out_words = out_sum[SUM_W-1:2];
  end

  assign start_take = (st == ST_IDLE) && pkt_start;
  assign in_active  = (st == ST_DATA) && !abort;
  assign cmd_ready  = (st == ST_IDLE) && !fifo_full && !pkt_start;
  assign cmd_fire   = cmd_ready && cmd_valid;
  assign rd_ready   = in_active && (in_left != '0) &&
                      (!held_valid || (!fifo_full && (out_left != '0)));
  assign rd_fire    = rd_ready && rd_valid;
  assign use_new    = (in_left != '0);
  assign data_fire  = in_active && held_valid && (out_left != '0) && !fifo_full &&
                      (!use_new || rd_valid);
  assign eop_fire   = (st == ST_EOP) && !fifo_full;
  assign last_word  = (out_left == LEN_W'(1));
  assign state      = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      in_left    <= '0;
      out_left   <= '0;
      held_valid <= 1'b0;
      aborted_q  <= 1'b0;
      off_q      <= 2'd0;
      lsb_q      <= 2'd0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_take) begin
            off_q      <= pkt_offset;
            lsb_q      <= pkt_len[1:0];
            in_left    <= in_words;
            out_left   <= out_words;
            aborted_q  <= 1'b0;
            held_valid <= 1'b0;
            st         <= (pkt_len == '0) ? ST_EOP : ST_DATA;
          end
        end
        ST_DATA: begin
          if (abort) begin
            aborted_q <= 1'b1;
            st        <= ST_EOP;
          end else begin
            if (rd_fire) begin
              in_left    <= in_left - LEN_W'(1);
              held_valid <= 1'b1;
            end
            if (data_fire) begin
              out_left <= out_left - LEN_W'(1);
              if (last_word) st <= ST_EOP;
            end
          end
        end
        ST_EOP: begin
          if (eop_fire) begin
            held_valid <= 1'b0;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: an abort in the data phase always lands in the end-of-packet step, flagged
  assert_abort_to_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && abort) |=> (st == ST_EOP && aborted_q));

  // R4: the end-of-packet write leaves the block idle with nothing held
  assert_eop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> (st == ST_IDLE && !held_valid));

  // R5: a zero-length packet skips straight to end of packet with no reads pending
  assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && pkt_len == '0) |=> (st == ST_EOP && in_left == '0));

  // R6: once a word is held, reads never run ahead of the payload still owed
  assert_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && held_valid) |-> (out_left >= in_left));

  // R10: a start strobe while busy leaves the packet setup untouched
  assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && pkt_start) |=> $stable({off_q, lsb_q}));

endmodule

// File: rtl/ur_shift.sv
module ur_shift
  import ur_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_fire,
  input  logic [31:0] rd_data,
  input  logic        flush,
  input  logic        use_new,
  input  logic [1:0]  off,
  input  logic        last_word,
  input  logic [1:0]  lsb,
  output logic [31:0] held_word,
  output logic [31:0] out_word
);

  logic [31:0] held_q;
  logic [31:0] nxt;
  logic [31:0] merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (flush)   held_q <= '0;
    else if (rd_fire) held_q <= rd_data;
  end

  always_comb begin
    nxt      = use_new ? rd_data : 32'h0;
    merged   = ur_merge(nxt, held_q, off);
    out_word = last_word ? (merged & ur_keep(lsb)) : merged;
  end

  assign held_word = held_q;

endmodule

// File: rtl/unaligned_realigner.sv
module unaligned_realigner
  import ur_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [1:0]       pkt_offset,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             abort,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic             rd_ready,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_data,
  output logic             cmd_ready,
  input  logic             fifo_full,
  output logic             fifo_wr,
  output logic [3:0]       fifo_tag,
  output logic [31:0]      fifo_data
);

  ur_state_e   state;
  logic        rd_fire, cmd_fire, data_fire, eop_fire;
  logic        use_new, last_word, held_valid, aborted_q;
  logic [1:0]  off_q, lsb_q;
  logic [31:0] held_word, out_word;

  ur_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pkt_start  (pkt_start),
    .pkt_offset (pkt_offset),
    .pkt_len    (pkt_len),
    .abort      (abort),
    .rd_valid   (rd_valid),
    .cmd_valid  (cmd_valid),
    .fifo_full  (fifo_full),
    .state      (state),
    .rd_ready   (rd_ready),
    .rd_fire    (rd_fire),
    .cmd_ready  (cmd_ready),
    .cmd_fire   (cmd_fire),
    .data_fire  (data_fire),
    .eop_fire   (eop_fire),
    .use_new    (use_new),
    .last_word  (last_word),
    .held_valid (held_valid),
    .aborted_q  (aborted_q),
    .off_q      (off_q),
    .lsb_q      (lsb_q)
  );

  ur_shift shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (rd_fire),
    .rd_data   (rd_data),
    .flush     (eop_fire),
    .use_new   (use_new),
    .off       (off_q),
    .last_word (last_word),
    .lsb       (lsb_q),
    .held_word (held_word),
    .out_word  (out_word)
  );

  assign fifo_wr = cmd_fire | data_fire | eop_fire;

  always_comb begin
    if (cmd_fire) begin
      fifo_tag  = TAG_CMD;
      fifo_data = cmd_data;
    end else if (data_fire) begin
      fifo_tag  = TAG_DATA;
      fifo_data = out_word;
    end else if (eop_fire) begin
      fifo_tag  = TAG_EOP;
      fifo_data = {23'h0, aborted_q, 6'h0, lsb_q};
    end else begin
      fifo_tag  = TAG_CMD;
      fifo_data = 32'h0;
    end
  end

  // R7: commands, payload and end of packet never compete for the port
  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_fire, data_fire, eop_fire}));

  // R8: nothing is written into a full FIFO
  assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);

  // R8: held bytes survive a full-FIFO stall unchanged
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && fifo_full && !abort && held_valid) |=> $stable(held_word));

endmodule

// File: tb/unaligned_realigner_tb_top.sv
`timescale 1ns/1ps
module unaligned_realigner_tb_top;

  localparam int LEN_W = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pkt_start;
  logic [1:0]       pkt_offset;
  logic [LEN_W-1:0] pkt_len;
  logic             abort;
  logic             rd_valid;
  logic [31:0]      rd_data;
  logic             rd_ready;
  logic             cmd_valid;
  logic [31:0]      cmd_data;
  logic             cmd_ready;
  logic             fifo_full;
  logic             fifo_wr;
  logic [3:0]       fifo_tag;
  logic [31:0]      fifo_data;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  unaligned_realigner #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_offset(pkt_offset),
    .pkt_len(pkt_len), .abort(abort), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_tag(fifo_tag), .fifo_data(fifo_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp<=150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + 5) & 255);
  endfunction

  function automatic logic [31:0] mem_word(input int w, input int seed);
    return {mem_byte(4*w+3, seed), mem_byte(4*w+2, seed),
            mem_byte(4*w+1, seed), mem_byte(4*w, seed)};
  endfunction

  // expected payload entry, built byte by byte from the memory image
  function automatic logic [31:0] exp_word(input int off, input int len,
                                           input int j, input int seed);
    logic [31:0] w;
    w = '0;
    for (int l = 0; l < 4; l++) begin
      if (4*j + l < len) w[8*l +: 8] = mem_byte(off + 4*j + l, seed);
    end
    return w;
  endfunction

  task automatic idle_inputs();
    pkt_start = 0; pkt_offset = 0; pkt_len = 0; abort = 0;
    rd_valid = 0; rd_data = 0; cmd_valid = 0; cmd_data = 0; fifo_full = 0;
  endtask

  task automatic run_pkt(input int off, input int len, input bit stall,
                         input int abort_at, input bit with_cmd,
                         input bit noise, input int seed);
    int nin, nout, widx, dseen, cyc;
    bit done, aborted, abort_now;
    logic [31:0] cword;
    nin   = (len == 0) ? 0 : (off + len + 3) / 4;
    nout  = (len + 3) / 4;
    widx  = 0; dseen = 0; cyc = 0; done = 0; aborted = 0;
    cword = 32'hC0DE_0000 ^ 32'(seed * 257 + len);
    @(negedge clk);
    idle_inputs();
    pkt_start = 1; pkt_offset = 2'(off); pkt_len = LEN_W'(len);
    while (!done && cyc < 300) begin
      @(negedge clk);
      pkt_start  = noise && (cyc == 2);
      pkt_offset = 2'(off + 1);
      pkt_len    = LEN_W'(len + 3);
      fifo_full  = stall ? (((cyc * 7 + 3) % 5) < 2) : 1'b0;
      rd_valid   = stall ? ((cyc % 4) != 1) : 1'b1;
      rd_data    = mem_word(widx, seed);
      cmd_valid  = with_cmd;
      cmd_data   = cword;
      abort_now  = (abort_at >= 0) && !aborted && (dseen == abort_at);
      abort      = abort_now;
      #1;
      if (with_cmd) chk(!cmd_ready, "R7", "cmd_ready while busy", 36'(cmd_ready), 36'h0);
      if (abort_now) begin
        aborted = 1;
        chk(!fifo_wr, "R9", "write in abort cycle", 36'(fifo_wr), 36'h0);
      end else if (fifo_wr) begin
        if (fifo_full) chk(0, "R8", "write while full", 36'(fifo_wr), 36'h0);
        if (fifo_tag == 4'h1) begin
          if (aborted || dseen >= nout)
            chk(0, "R9", "extra payload entry", 36'(fifo_data), 36'h0);
          else if (dseen == nout - 1)
            chk(fifo_data == exp_word(off, len, dseen, seed), "R3", "last payload",
                36'(fifo_data), 36'(exp_word(off, len, dseen, seed)));
          else
            chk(fifo_data == exp_word(off, len, dseen, seed), "R2", "payload",
                36'(fifo_data), 36'(exp_word(off, len, dseen, seed)));
          dseen++;
        end else if (fifo_tag == 4'h2) begin
          chk(aborted || dseen == nout, "R4", "eop after payload count",
              36'(dseen), 36'(nout));
          chk(fifo_data == {23'h0, aborted, 6'h0, 2'(len)}, "R4", "eop data",
              36'(fifo_data), 36'({23'h0, aborted, 6'h0, 2'(len)}));
          if (len == 0) chk(dseen == 0, "R5", "payload on zero length", 36'(dseen), 36'h0);
          done = 1;
        end else begin
          chk(0, "R7", "command or bad tag during packet", 36'(fifo_tag), 36'h1);
        end
      end
      if (rd_ready && rd_valid) widx++;
      cyc++;
    end
    chk(done, "R4", "eop seen", 36'(done), 36'h1);
    if (!aborted) begin
      if (len == 0) chk(widx == 0, "R5", "reads on zero length", 36'(widx), 36'h0);
      else chk(widx == nin, "R6", "memory words consumed", 36'(widx), 36'(nin));
    end
    @(negedge clk);
    idle_inputs();
    if (with_cmd) begin
      cmd_valid = 1; cmd_data = cword;
      #1;
      chk(fifo_wr && fifo_tag == 4'h0 && fifo_data == cword, "R7", "command after idle",
          {fifo_tag, fifo_data}, {4'h0, cword});
      @(negedge clk);
      idle_inputs();
    end
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!fifo_wr && !rd_ready, "R1", "reset writes/reads", {34'h0, fifo_wr, rd_ready}, 36'h0);
    chk(cmd_ready, "R1", "reset cmd_ready", 36'(cmd_ready), 36'h1);

    // command in idle against a full FIFO, then released
    @(negedge clk);
    cmd_valid = 1; cmd_data = 32'hA5A5_0F0F; fifo_full = 1;
    #1;
    chk(!fifo_wr && !cmd_ready, "R8", "command into full FIFO", {34'h0, fifo_wr, cmd_ready}, 36'h0);
    @(negedge clk);
    fifo_full = 0;
    #1;
    chk(fifo_wr && fifo_tag == 4'h0 && fifo_data == 32'hA5A5_0F0F, "R7", "idle command",
        {fifo_tag, fifo_data}, {4'h0, 32'hA5A5_0F0F});
    @(negedge clk);
    idle_inputs();

    // sweep: every offset against lengths 0..23, free flow and stalled
    for (int st = 0; st < 2; st++)
      for (int off = 0; off < 4; off++)
        for (int len = 0; len < 24; len++)
          run_pkt(off, len, st[0], -1, 0, 0, off * 31 + len);

    // R9: aborts at several payload positions, each followed by a clean packet
    for (int off = 0; off < 4; off++)
      for (int ab = 0; ab < 3; ab++) begin
        run_pkt(off, 13, ab[0], ab, 0, 0, 7 + ab);
        run_pkt(3 - off, 9, 0, -1, 0, 0, 40 + off);
      end

    // R7: commands held against a busy block
    for (int off = 0; off < 4; off++) begin
      run_pkt(off, 6 + off, 0, -1, 1, 0, 90 + off);
      run_pkt(off, 0, 1, -1, 1, 0, 95 + off);
    end

    // R10: start strobes injected mid-packet
    for (int off = 0; off < 4; off++)
      run_pkt(off, 17, off[0], -1, 0, 1, 120 + off);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule